// File: doc/BRIEF.md
# Column-Sum Crosswise Multiplier

This block multiplies two unsigned N-bit operands and returns the full 2N-bit product. It uses the vertical-and-crosswise method. Every bit pair `a[i] & b[j]` is formed at once by a plane of AND gates. The bits are then grouped into 2N-1 diagonal columns, indexed by `i + j`. Each column adds its own bits plus the carry handed up from the column below. The low bit of that total becomes the product bit for the column, and the rest of the total moves on as the carry into the next column. The carry that leaves the top column is the most significant product bit.

The whole column chain is combinational. A single register stage sits at the output. A caller presents both operands with `in_valid` high, and the product appears with `out_valid` high one clock later. While `in_valid` is low, the registered product keeps its last value. The default width is 8 bits, giving a 16-bit product. The width parameter is intended for values up to 64.

Top module: `vedic_col_mult`

## Requirements
- R1: When `in_valid` is high at a rising edge, `prod_out` after that edge equals the unsigned product `a_in * b_in`, zero-extended to 2N bits.
- R2: `out_valid` after each rising edge equals the value `in_valid` had at that edge.
- R3: When `in_valid` is low at a rising edge, `prod_out` keeps its previous value, whatever `a_in` and `b_in` are.
- R4: While `rst` is high at a rising edge, `prod_out` becomes 0 and `out_valid` becomes 0. `rst` is synchronous and takes priority over `in_valid`.
- R5: The carry that leaves column 2N-2 is a single bit and becomes product bit 2N-1. No carry weight reaches beyond bit 2N-1, so all-ones operands give (2^N-1)^2, which is 65025 for N=8.
- R6: Any operand multiplied by zero gives 0, and any operand multiplied by 1 gives that operand unchanged, whichever input port carries the 0 or the 1.
- R7: Operands presented on consecutive cycles with `in_valid` held high each give their own product on the following cycle, with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are valid this cycle |
| a_in | input | N | Unsigned operand A |
| b_in | input | N | Unsigned operand B |
| prod_out | output | 2N | Registered unsigned product |
| out_valid | output | 1 | `prod_out` was loaded on the last edge |

## Verification
The hardest case to reach from the ports is the longest carry: totals in the middle columns large enough that carries travel all the way into the top column and out as bit 2N-1. Random operands seldom set every bit in both operands. The stimulus therefore includes directed all-ones and near-all-ones pairs, such as all-ones times all-ones and all-ones times (all-ones minus one). These are mixed into a random stream in which `in_valid` toggles. The same stream also exercises back-to-back loading and holding.

// File: rtl/vm_pkg.sv
package vm_pkg;
  // Width of the inter-column carry bus. It must hold the total of one
  // column: up to N partial products plus the carry coming from below.
  function automatic int vm_carry_w(input int n);
    return $clog2(n) + 2;
  endfunction
endpackage

// File: rtl/vm_pp_gen.sv
module vm_pp_gen #(
  parameter int N = 8
) (
  input  logic [N-1:0] a_op,
  input  logic [N-1:0] b_op,
  output logic [N-1:0] col_pp [2*N-1]
);
  localparam int NCOL = 2*N - 1;

  // Slot i of column k holds a[i] & b[k-i], or zero where k-i is out of range.
  for (genvar k = 0; k < NCOL; k++) begin : g_col
    for (genvar i = 0; i < N; i++) begin : g_bit
      if ((k - i >= 0) && (k - i < N)) begin : g_and
        assign col_pp[k][i] = a_op[i] & b_op[k-i];
      end else begin : g_zero
        assign col_pp[k][i] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/vm_col_adder.sv
module vm_col_adder #(
  parameter int N  = 8,
  parameter int CW = 5
) (
  input  logic [N-1:0]  pp,
  input  logic [CW-1:0] cin,
  output logic          sum_bit,
  output logic [CW-1:0] cout
);
  logic [CW-1:0] total;

  always_comb begin
    total = cin;
    for (int i = 0; i < N; i++) begin
      total = total + CW'(pp[i]);
    end
    sum_bit = total[0];
    cout    = {1'b0, total[CW-1:1]};
  end
endmodule

// File: rtl/vm_col_chain.sv
module vm_col_chain #(
  parameter int N  = 8,
  parameter int CW = 5
) (
  input  logic [N-1:0]   col_pp [2*N-1],
  output logic [2*N-2:0] low_bits,
  output logic [CW-1:0]  final_carry
);
  localparam int NCOL = 2*N - 1;

  logic [CW-1:0] carry [NCOL+1];

  assign carry[0] = '0;

  for (genvar k = 0; k < NCOL; k++) begin : g_stage
    vm_col_adder #(.N(N), .CW(CW)) u_col (
      .pp      (col_pp[k]),
      .cin     (carry[k]),
      .sum_bit (low_bits[k]),
      .cout    (carry[k+1])
    );
  end

  assign final_carry = carry[NCOL];
endmodule

// File: rtl/vedic_col_mult.sv
module vedic_col_mult #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [N-1:0]   a_in,
  input  logic [N-1:0]   b_in,
  output logic [2*N-1:0] prod_out,
  output logic           out_valid
);
  localparam int PW   = 2*N;
  localparam int NCOL = 2*N - 1;
  localparam int CW   = vm_pkg::vm_carry_w(N);

  logic [N-1:0]    col_pp [NCOL];
  logic [PW-2:0]   low_bits;
  logic [CW-1:0]   final_carry;
  logic [PW-1:0]   comb_prod;
  logic [CW-2:0]   top_spill;

  vm_pp_gen #(.N(N)) u_pp (
    .a_op   (a_in),
    .b_op   (b_in),
    .col_pp (col_pp)
  );

  vm_col_chain #(.N(N), .CW(CW)) u_chain (
    .col_pp      (col_pp),
    .low_bits    (low_bits),
    .final_carry (final_carry)
  );

  assign comb_prod = {final_carry[0], low_bits};
  assign top_spill = final_carry[CW-1:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_out  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        prod_out <= comb_prod;
      end
    end
  end
endmodule

// File: rtl/vedic_col_mult_chk.sv
module vedic_col_mult_chk #(
  parameter int N  = 8,
  parameter int CW = 5
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic [N-1:0]   a_in,
  input logic [N-1:0]   b_in,
  input logic [2*N-1:0] prod_out,
  input logic           out_valid,
  input logic [CW-2:0]  top_spill
);
  AST_PRODUCT_MATCH: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> prod_out == ((2*N)'($past(a_in)) * (2*N)'($past(b_in)))); // R1

  AST_VALID_SET: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R2

  AST_VALID_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R2

  AST_HOLD_PRODUCT: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(prod_out)); // R3

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (prod_out == '0) && !out_valid); // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    top_spill == '0); // R5
endmodule

bind vedic_col_mult vedic_col_mult_chk #(.N(N), .CW(CW)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .a_in      (a_in),
  .b_in      (b_in),
  .prod_out  (prod_out),
  .out_valid (out_valid),
  .top_spill (top_spill)
);

// File: tb/vedic_col_mult_tb.sv
module vedic_col_mult_tb_top;
  localparam int N  = 8;
  localparam int PW = 2*N;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [N-1:0]  a_in = '0;
  logic [N-1:0]  b_in = '0;
  logic [PW-1:0] prod_out;
  logic          out_valid;

  int checks   = 0;
  int failures = 0;
  logic [PW-1:0] exp_prod  = '0;
  logic          exp_valid = 1'b0;
  string         cur_tag   = "R1";

  always #2.5 clk = ~clk;

  vedic_col_mult #(.N(N)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .a_in      (a_in),
    .b_in      (b_in),
    .prod_out  (prod_out),
    .out_valid (out_valid)
  );

  function automatic logic [PW-1:0] ref_mul(input logic [N-1:0] x, input logic [N-1:0] y);
    logic [PW-1:0] acc = '0;
    for (int i = 0; i < N; i++) begin
      if (y[i]) acc = acc + (PW'(x) << i);
    end
    return acc;
  endfunction

  task automatic check_val(input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // At the falling edge: compare outputs with the model, then drive the next inputs.
  task automatic step(input logic [N-1:0] x, input logic [N-1:0] y, input logic v, input string tag);
    @(negedge clk);
    check_val({cur_tag, " prod"}, prod_out, exp_prod);
    check_val("R2 valid", PW'(out_valid), PW'(exp_valid));
    a_in = x; b_in = y; in_valid = v;
    cur_tag = tag;
    if (v) exp_prod = ref_mul(x, y);
    exp_valid = v;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1; a_in = '1; b_in = '1;
    @(negedge clk);
    check_val("R4 prod", prod_out, '0);
    check_val("R4 valid", PW'(out_valid), '0);
    rst = 1'b0; in_valid = 1'b0;
    exp_prod = '0; exp_valid = 1'b0; cur_tag = "R4";
  endtask

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    step(8'd0,   8'd0,   1'b1, "R6");
    step(8'd255, 8'd255, 1'b1, "R5");
    step(8'd255, 8'd254, 1'b1, "R5");
    step(8'd1,   8'd173, 1'b1, "R6");
    step(8'd91,  8'd1,   1'b1, "R6");
    step(8'd0,   8'd200, 1'b1, "R6");
    step(8'd77,  8'd0,   1'b1, "R6");
    step(8'd128, 8'd128, 1'b1, "R7");
    step(8'd12,  8'd34,  1'b1, "R7");
    // Operands change while in_valid is low: product must hold.
    step(8'd255, 8'd255, 1'b0, "R3");
    step(8'd3,   8'd5,   1'b0, "R3");
    step(8'd3,   8'd5,   1'b1, "R1");
    for (int n = 0; n < 400; n++) begin
      logic [N-1:0] x = N'($urandom);
      logic [N-1:0] y = N'($urandom);
      logic v = ($urandom % 4) != 0;
      if (n % 50 == 7) begin x = '1; y = N'($urandom) | 8'hF0; end
      step(x, y, v, v ? "R1" : "R3");
    end
    do_reset();
    step(8'd200, 8'd201, 1'b1, "R1");
    step(8'd0,   8'd0,   1'b0, "R3");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5ns * 20000);
    failures++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule